// File: doc/BRIEF.md
# Variable-Group Carry-Skip Adder

This block adds two unsigned operands and a carry input. It returns a sum of the same width and a carry output. The adder is split into ripple-carry groups of unequal length. The lengths come from a parameter list, and by default they are 2, 3, 4, 4 and 3 bits, counted from the least significant end. Inside each group the carry ripples from bit to bit. Each group also forms a group propagate, which is the AND of its bitwise propagates. A multiplexer driven by that signal lets the carry entering the group pass straight to the next group whenever every bit would pass it on anyway.

A subtract control reuses the same datapath. It inverts the second operand and forces the carry into the lowest bit to one, so the adder computes a minus b in two's complement. The carry output is then a "no borrow" flag.

The carry-skip core is combinational. The result is captured in an output register with a synchronous, active-high reset, so the result appears one clock after the operands are presented.

Top module: `csk_adder`

## Requirements
- R1: With `sub` = 0, the value {`cout`,`sum`} seen after the clock edge that samples `a`, `b` and `cin` equals the 17-bit value a + b + cin.
- R2: With `sub` = 1, {`cout`,`sum`} equals a + (~b) + 1 taken to 17 bits, and `cin` has no effect. `cout` = 1 exactly when a ≥ b as unsigned numbers.
- R3: While `rst` is high at a clock edge, the registers load zero, so after that edge `sum` = 0 and `cout` = 0.
- R4: When every bit of a group propagates, the carry entering the group leaves it unchanged. For example, a ^ b = all ones gives {cout,sum} = {cin, ~cin repeated}.
- R5: When a group holds at least one non-propagating bit, its carry-out is the one made by its internal ripple chain. This covers a carry generated at the top bit of one group and carried into the next group, at every group boundary.
- R6: The group lengths are a parameter list whose entries must add up to the operand width. The default partition is 2,3,4,4,3 from LSB to MSB.
- R7: The result register updates on every clock edge outside reset, so back-to-back operand sets give back-to-back results one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (inverted when subtracting) |
| cin | input | 1 | Carry input, ignored when subtracting |
| sub | input | 1 | 1 selects a - b |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out (no-borrow when subtracting) |

## Verification
A wrong group propagate, or a wrong skip selection, corrupts the carry entering the following group. That error shows up in the sum bits above the faulty boundary, and possibly in `cout`, on the very next clock edge after the operands are applied. The directed patterns set up all-propagate groups and carries generated just below each boundary, so every skip multiplexer and every ripple chain is forced to decide the upper bits. Random operands in both modes then cover the remaining mixes of propagate, generate and kill bits.

// File: rtl/csk_pkg.sv
package csk_pkg;
  localparam int unsigned CSK_MAX_GROUPS = 16;

  // one bit of carry recurrence: out = g | (p & c)
  function automatic logic carry_step(input logic gen, input logic prop, input logic cin_b);
    return gen | (prop & cin_b);
  endfunction
endpackage

// File: rtl/csk_pg.sv
module csk_pg #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign prop[i] = x[i] ^ y[i];
      assign gen[i]  = x[i] & y[i];
    end
  endgenerate
endmodule

// File: rtl/csk_group.sv
module csk_group #(
  parameter int unsigned LEN = 4
) (
  input  logic [LEN-1:0] prop,
  input  logic [LEN-1:0] gen,
  input  logic           c_in,
  output logic [LEN-1:0] c_bits,
  output logic           c_out
);
  import csk_pkg::*;

  logic [LEN:0] chain;
  logic         grp_prop;

  assign chain[0] = c_in;

  genvar i;
  generate
    for (i = 0; i < LEN; i++) begin : g_rip
      assign chain[i+1] = carry_step(gen[i], prop[i], chain[i]);
    end
  endgenerate

  assign c_bits   = chain[LEN-1:0];
  assign grp_prop = &prop;
  // skip multiplexer: bypass the chain when the whole group propagates
  assign c_out    = grp_prop ? c_in : chain[LEN];

  // the ripple result must agree with the bypass whenever the skip is taken
  always_comb begin
    if (grp_prop) begin
      assert_skip_agrees_R4: assert (chain[LEN] == c_in);
    end
  end
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned NGRP  = 5,
  parameter int unsigned GLEN [NGRP] = '{2, 3, 4, 4, 3}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  function automatic int unsigned grp_ofs(input int unsigned idx);
    int unsigned s;
    s = 0;
    for (int unsigned k = 0; k < idx; k++) s += GLEN[k];
    return s;
  endfunction

  localparam int unsigned TOTAL = grp_ofs(NGRP);

  initial begin
    assert_partition_sum_R6: assert (TOTAL == WIDTH && NGRP <= csk_pkg::CSK_MAX_GROUPS)
      else $error("group lengths add to %0d, width is %0d", TOTAL, WIDTH);
  end

  logic [WIDTH-1:0] b_eff;
  logic             c0;
  logic [WIDTH-1:0] prop, gen;
  wire  [WIDTH-1:0] cvec;
  wire  [NGRP:0]    gcarry;

  assign b_eff = sub ? ~b : b;
  assign c0    = sub ? 1'b1 : cin;

  csk_pg #(.W(WIDTH)) u_pg (
    .x   (a),
    .y   (b_eff),
    .prop(prop),
    .gen (gen)
  );

  assign gcarry[0] = c0;

  genvar gi;
  generate
    for (gi = 0; gi < NGRP; gi++) begin : g_grp
      localparam int unsigned OFS = grp_ofs(gi);
      localparam int unsigned LEN = GLEN[gi];
      csk_group #(.LEN(LEN)) u_grp (
        .prop  (prop[OFS +: LEN]),
        .gen   (gen[OFS +: LEN]),
        .c_in  (gcarry[gi]),
        .c_bits(cvec[OFS +: LEN]),
        .c_out (gcarry[gi+1])
      );
    end
  endgenerate

  logic [WIDTH-1:0] sum_c;
  assign sum_c = prop ^ cvec;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= gcarry[NGRP];
    end
  end

  // armed: previous edge was outside reset, so the output reflects sampled inputs
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_add_result_R1: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(sub)) |->
      ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)})));

  assert_sub_result_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(sub)) |->
      ({cout, sum} == ({1'b0, $past(a)} + {1'b0, ~$past(b)} + {{WIDTH{1'b0}}, 1'b1})));

  assert_reset_clear_R3: assert property (@(posedge clk)
    rst |=> (sum == '0 && !cout));
endmodule

// File: tb/csk_adder_tb.sv
module csk_adder_tb;
  localparam int unsigned W = 16;

  logic         clk = 0;
  logic         rst = 1;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 0, sub = 0;
  logic [W-1:0] sum;
  logic         cout;

  always #5 clk = ~clk;

  csk_adder u_dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sub(sub),
    .sum(sum), .cout(cout)
  );

  typedef struct {
    logic [W:0] exp;
    int         tag;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic xc, input logic xs, input string req);
    item_t it;
    @(negedge clk);
    a = xa; b = xb; cin = xc; sub = xs;
    if (xs) it.exp = {1'b0, xa} + {1'b0, ~xb} + 17'd1;
    else    it.exp = {1'b0, xa} + {1'b0, xb} + {16'd0, xc};
    it.tag = cyc;
    it.req = req;
    q.push_back(it);
  endtask

  // monitor: compare results one cycle after their operands were applied
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].tag < cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({cout, sum} !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.req, {cout, sum}, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam int BND [4] = '{2, 5, 9, 13};

  initial begin
    // R3: reset clears outputs, even with live operands
    a = 16'hFFFF; b = 16'h0001; cin = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({cout, sum} !== 17'd0) begin
      errors++;
      $display("FAIL R3: got %h expected %h", {cout, sum}, 17'd0);
    end
    rst = 0;

    // R4: all-propagate, carry skips every group
    drive(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R4");
    drive(16'hFFFF, 16'h0000, 1'b0, 1'b0, "R4");
    drive(16'hA5C3, 16'h5A3C, 1'b1, 1'b0, "R4");
    drive(16'hA5C3, 16'h5A3C, 1'b0, 1'b0, "R4");
    // R5: carry generated just below each boundary, upper bits propagate
    foreach (BND[k]) begin
      logic [W-1:0] top;
      top = 16'hFFFF << BND[k];
      drive(top | (16'd1 << (BND[k]-1)), 16'd1 << (BND[k]-1), 1'b0, 1'b0, "R5");
      drive(top, 16'd1 << (BND[k]-1), 1'b0, 1'b0, "R5");
    end
    // R1: basic additions, back-to-back (R7)
    drive(16'h0000, 16'h0000, 1'b0, 1'b0, "R1");
    drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R1");
    drive(16'h1234, 16'h4321, 1'b1, 1'b0, "R7");
    // R2: subtraction, cin must not matter
    drive(16'h0005, 16'h0003, 1'b0, 1'b1, "R2");
    drive(16'h0003, 16'h0005, 1'b1, 1'b1, "R2");
    drive(16'h8000, 16'h8000, 1'b0, 1'b1, "R2");
    drive(16'h0000, 16'hFFFF, 1'b1, 1'b1, "R2");
    // R6: default partition exercised by randoms in both modes
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] ra, rb;
      logic rs;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rs = n[0];
      drive(ra, rb, 1'($urandom), rs, rs ? "R2" : "R6");
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule